// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave side of a two-wire serial memory. It oversamples the clock and data lines with a fast system clock, finds START and STOP conditions, and shifts in a control byte. It acknowledges only when the device code and two strap inputs match and no internal program cycle is running. A write transaction loads a word address into a 9-bit pointer, then collects data bytes into an 8-entry page buffer. A STOP commits that buffer to a 512x8 register array through a self-timed program sequencer. A read transaction streams bytes from the pointer, most significant bit first, for as long as the master acknowledges.

The lowest chip-address bit of the control byte is not compared with a strap. It selects one of two 256-byte blocks and becomes pointer bit 8. The pointer never leaves its block.

The only external interface is the bus itself: an open-drain data line, modelled as an active-high pull-low enable, and plain strap inputs. Inside the block, the path from the protocol engine to the page buffer is a valid/ready pair. The engine asserts valid for one cycle only when ready is high. Ready is low for the whole program cycle, and during that time the engine refuses to acknowledge. No data is ever held waiting on back-pressure.

Top module: `tw_eeprom_slave`

## Requirements
- R1: A falling data line while the clock is high is a START, and a rising data line while the clock is high is a STOP. A START in any state, including partway through a byte, restarts control-byte reception.
- R2: The control byte is sent MSB first. Its bits [7:4] must equal 1010 and bits [3:2] must equal `strap_i[1:0]` for an acknowledge. Bit 1 is the block select and bit 0 is the direction (1 = read). A mismatch is not acknowledged.
- R3: An acknowledge pulls the data line low for the whole high phase of the ninth clock and releases it after that clock falls. The pull-low enable only rises while the clock is low.
- R4: In a write, the byte after the control byte loads pointer bits [7:0], and the block select loads pointer bit 8.
- R5: Data bytes are stored in the page buffer at pointer bits [2:0], which then increment modulo 8 while bits [8:3] stay fixed. A ninth or later byte overwrites the earliest ones. A STOP commits the buffered bytes to the array.
- R6: While a program cycle runs, no control byte is acknowledged, even one that matches. The cycle lasts PROG_CYCLES clocks per buffered byte, and the array is written only during it.
- R7: A read control byte starts transmission of the byte at the pointer, MSB first, and the pointer then increments. Transmission continues while the master acknowledges. After a master non-acknowledge the data line is released and stays released until the next START.
- R8: Pointer increments wrap from xFF to x00 inside the same block. Bit 8 changes only through a control byte.
- R9: A read may start at the current pointer with no word-address phase. A repeated START after the word address switches the transaction into a read.
- R10: After reset the pull-low enable is low, the pointer is 0 and every array byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| strap_i | input | 2 | Chip-select straps compared with control bits [3:2] |
| sda_pull_o | output | 1 | High to pull the data line low |

## Verification
The hardest situation to reach from the ports is the program-cycle window. A control byte has to land inside it and be refused, and then the same address has to be acknowledged once the window closes. The stimulus issues a write-direction control byte straight after every committing STOP. It expects the first poll to go unacknowledged, then keeps polling until an acknowledge arrives. Two other corners are driven directly. Overlong pages exercise buffer overwrite. Reads that start near xFF in both blocks exercise block wrap. Random page writes followed by random and current-address reads cover the rest.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_WADDR,
    ST_WDATA,
    ST_READ
  } eng_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s   = scl_ff[STAGES-1];
  assign sda_o   = sda_ff[STAGES-1];
  assign rise_o  = scl_s & ~scl_q;
  assign fall_o  = ~scl_s & scl_q;
  assign start_o = scl_s & scl_q & sda_q & ~sda_o;
  assign stop_o  = scl_s & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/tw_proto_engine.sv
module tw_proto_engine
  import tw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sda_s,
  input  logic                     start_i,
  input  logic                     stop_i,
  input  logic                     rise_i,
  input  logic                     fall_i,
  input  logic [1:0]               strap_i,
  input  logic                     busy_i,
  output logic                     sda_pull_o,
  output logic [ADDR_W-1:0]        ptr_o,
  input  logic [7:0]               rd_data_i,
  output logic                     push_valid_o,
  input  logic                     push_ready_i,
  output logic [PAGE_W-1:0]        push_idx_o,
  output logic [7:0]               push_data_o,
  output logic [ADDR_W-PAGE_W-1:0] push_base_o,
  output eng_state_e               state_o
);
  localparam int BLK_W = ADDR_W - 1;

  eng_state_e  state;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg, tx;
  logic        rw_q, mack, ctrl_hit;
  logic [ADDR_W-1:0] ptr;

  assign ctrl_hit = (shreg[7:4] == DEV_CODE) && (shreg[3:2] == strap_i) && !busy_i;
  assign ptr_o    = ptr;
  assign state_o  = state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      bitcnt       <= '0;
      shreg        <= '0;
      tx           <= '0;
      rw_q         <= 1'b0;
      mack         <= 1'b0;
      ptr          <= '0;
      sda_pull_o   <= 1'b0;
      push_valid_o <= 1'b0;
      push_idx_o   <= '0;
      push_data_o  <= '0;
      push_base_o  <= '0;
    end else begin
      push_valid_o <= 1'b0;
      if (start_i) begin
        state      <= ST_CTRL;
        bitcnt     <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_i) begin
        state      <= ST_IDLE;
        bitcnt     <= '0;
        sda_pull_o <= 1'b0;
      end else if (rise_i && state != ST_IDLE) begin
        if (bitcnt < 4'd8) begin
          if (state != ST_READ) shreg <= {shreg[6:0], sda_s};
        end else if (bitcnt == 4'd8 && state == ST_READ) begin
          mack <= ~sda_s;
        end
        if (bitcnt < 4'd9) bitcnt <= bitcnt + 4'd1;
      end else if (fall_i && state != ST_IDLE) begin
        if (bitcnt == 4'd8) begin
          unique case (state)
            ST_CTRL: begin
              if (ctrl_hit) begin
                sda_pull_o      <= 1'b1;
                ptr[ADDR_W-1]   <= shreg[1];
                rw_q            <= shreg[0];
              end else begin
                state <= ST_IDLE;
              end
            end
            ST_WADDR: begin
              sda_pull_o      <= 1'b1;
              ptr[BLK_W-1:0]  <= shreg;
            end
            ST_WDATA: begin
              if (push_ready_i) begin
                sda_pull_o            <= 1'b1;
                push_valid_o          <= 1'b1;
                push_idx_o            <= ptr[PAGE_W-1:0];
                push_data_o           <= shreg;
                push_base_o           <= ptr[ADDR_W-1:PAGE_W];
                ptr[PAGE_W-1:0]       <= ptr[PAGE_W-1:0] + 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
            default: sda_pull_o <= 1'b0;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt     <= '0;
          sda_pull_o <= 1'b0;
          unique case (state)
            ST_CTRL: begin
              if (rw_q) begin
                state      <= ST_READ;
                tx         <= rd_data_i;
                sda_pull_o <= ~rd_data_i[7];
                ptr        <= {ptr[ADDR_W-1], ptr[BLK_W-1:0] + 1'b1};
              end else begin
                state <= ST_WADDR;
              end
            end
            ST_WADDR: state <= ST_WDATA;
            ST_READ: begin
              if (mack) begin
                tx         <= rd_data_i;
                sda_pull_o <= ~rd_data_i[7];
                ptr        <= {ptr[ADDR_W-1], ptr[BLK_W-1:0] + 1'b1};
              end else begin
                state <= ST_IDLE;
              end
            end
            default: state <= state;
          endcase
        end else if (state == ST_READ && bitcnt != 4'd0) begin
          sda_pull_o <= ~tx[6];
          tx         <= {tx[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/tw_page_prog.sv
module tw_page_prog #(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 3,
  parameter int PROG_CYCLES = 300
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_valid_i,
  output logic                     push_ready_o,
  input  logic [PAGE_W-1:0]        push_idx_i,
  input  logic [7:0]               push_data_i,
  input  logic [ADDR_W-PAGE_W-1:0] push_base_i,
  input  logic                     commit_i,
  output logic                     busy_o,
  output logic                     we_o,
  output logic [ADDR_W-1:0]        waddr_o,
  output logic [7:0]               wdata_o
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TMR_W = $clog2(PROG_CYCLES + 1);
  localparam logic [TMR_W-1:0]  LAST_TMR = TMR_W'(PROG_CYCLES - 1);
  localparam logic [PAGE_W-1:0] LAST_IDX = '1;

  logic [7:0]              pbuf [PAGE];
  logic [PAGE-1:0]         pvld;
  logic [ADDR_W-PAGE_W-1:0] base;
  logic [PAGE_W-1:0]       sidx;
  logic [TMR_W-1:0]        tmr;
  logic                    step;

  assign push_ready_o = ~busy_o;
  assign step = busy_o && (!pvld[sidx] || tmr == LAST_TMR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
      pvld    <= '0;
      base    <= '0;
      sidx    <= '0;
      tmr     <= '0;
      busy_o  <= 1'b0;
      we_o    <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      we_o <= 1'b0;
      if (!busy_o) begin
        if (push_valid_i) begin
          pbuf[push_idx_i] <= push_data_i;
          pvld[push_idx_i] <= 1'b1;
          base             <= push_base_i;
        end
        if (commit_i && |pvld) begin
          busy_o <= 1'b1;
          sidx   <= '0;
          tmr    <= '0;
        end
      end else begin
        if (pvld[sidx]) begin
          if (tmr == LAST_TMR) begin
            tmr        <= '0;
            we_o       <= 1'b1;
            waddr_o    <= {base, sidx};
            wdata_o    <= pbuf[sidx];
            pvld[sidx] <= 1'b0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        if (step) begin
          if (sidx == LAST_IDX) busy_o <= 1'b0;
          else                  sidx   <= sidx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tw_cell_array.sv
module tw_cell_array #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we_i) begin
      cells[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
  import tw_eeprom_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int PROG_CYCLES = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  output logic       sda_pull_o
);
  logic sda_s, start_p, stop_p, rise_p, fall_p;
  logic prog_busy, push_valid, push_ready, mem_we;
  logic [PAGE_W-1:0] push_idx;
  logic [7:0] push_data, rd_data, mem_wdata;
  logic [ADDR_W-PAGE_W-1:0] push_base;
  logic [ADDR_W-1:0] ptr, mem_waddr;
  eng_state_e eng_state;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .start_o(start_p), .stop_o(stop_p),
    .rise_o(rise_p), .fall_o(fall_p)
  );

  tw_proto_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .start_i(start_p), .stop_i(stop_p), .rise_i(rise_p), .fall_i(fall_p),
    .strap_i(strap_i), .busy_i(prog_busy), .sda_pull_o(sda_pull_o),
    .ptr_o(ptr), .rd_data_i(rd_data),
    .push_valid_o(push_valid), .push_ready_i(push_ready),
    .push_idx_o(push_idx), .push_data_o(push_data), .push_base_o(push_base),
    .state_o(eng_state)
  );

  tw_page_prog #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst_n(rst_n),
    .push_valid_i(push_valid), .push_ready_o(push_ready),
    .push_idx_i(push_idx), .push_data_i(push_data), .push_base_i(push_base),
    .commit_i(stop_p), .busy_o(prog_busy),
    .we_o(mem_we), .waddr_o(mem_waddr), .wdata_o(mem_wdata)
  );

  tw_cell_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we_i(mem_we), .waddr_i(mem_waddr),
    .wdata_i(mem_wdata), .raddr_i(ptr), .rdata_o(rd_data)
  );
endmodule

// File: rtl/tw_eeprom_slave_chk.sv
module tw_eeprom_slave_chk
  import tw_eeprom_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_pull_o,
  input logic       prog_busy,
  input logic       mem_we,
  input logic       push_valid,
  input logic       ptr_blk,
  input eng_state_e eng_state
);
  // R3
  pull_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_i);

  // R6
  we_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(prog_busy));

  // R6
  push_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> !prog_busy);

  // R8
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(ptr_blk) |-> $past(eng_state) == ST_CTRL);

  // R7
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_state == ST_IDLE |-> !sda_pull_o);
endmodule

bind tw_eeprom_slave tw_eeprom_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .prog_busy(prog_busy), .mem_we(mem_we), .push_valid(push_valid),
  .ptr_blk(ptr[ADDR_W-1]), .eng_state(eng_state)
);

// File: tb/tw_eeprom_slave_bench.sv
module tw_eeprom_slave_bench;
  localparam int Q = 6;
  localparam logic [1:0] STRAP = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  wire  sda_bus = sda_m & ~sda_pull;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit last_rel;
  logic [7:0] model [0:511];
  logic [8:0] mptr;
  logic [7:0] wbuf [0:15];

  always #10 clk = ~clk;

  tw_eeprom_slave u_tw_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_i(STRAP), .sda_pull_o(sda_pull)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] ctrl(input logic blk, input logic rd);
    return {4'b1010, STRAP, blk, rd};
  endfunction

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic m_start;
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; sda_m = 1'b0; wq; scl_m = 1'b0; wq;
  endtask

  task automatic m_stop;
    sda_m = 1'b0; wq; scl_m = 1'b1; wq; sda_m = 1'b1; wq; wq;
  endtask

  task automatic m_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq;
    end
  endtask

  task automatic m_wbyte(input logic [7:0] b, output bit ack);
    m_bits(b, 8);
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; ack = !sda_bus; wq; scl_m = 1'b0; wq;
    last_rel = !sda_pull;
  endtask

  task automatic m_rbyte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq; scl_m = 1'b1; wq; b[i] = sda_bus; wq; scl_m = 1'b0; wq;
    end
    sda_m = mack ? 1'b0 : 1'b1; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq;
    sda_m = 1'b1;
  endtask

  task automatic poll_ready(input logic blk, input bit expect_busy);
    bit ack;
    int n = 0;
    m_start; m_wbyte(ctrl(blk, 1'b0), ack); m_stop;
    if (expect_busy) chk(!ack, "R6 busy nack", ack, 0);
    while (!ack && n < 200) begin
      m_start; m_wbyte(ctrl(blk, 1'b0), ack); m_stop;
      n++;
    end
    chk(ack, "R6 ack after cycle", ack, 1);
  endtask

  task automatic do_write(input logic blk, input logic [7:0] addr, input int n);
    bit ack;
    m_start;
    m_wbyte(ctrl(blk, 1'b0), ack);
    chk(ack, "R2 write ctrl ack", ack, 1);
    chk(last_rel, "R3 ack released", last_rel, 1);
    m_wbyte(addr, ack);
    chk(ack, "R4 word addr ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      m_wbyte(wbuf[k], ack);
      chk(ack, "R5 data ack", ack, 1);
      model[{blk, addr[7:3], 3'(addr[2:0] + k)}] = wbuf[k];
    end
    m_stop;
    mptr = {blk, addr[7:3], 3'(addr[2:0] + n)};
    poll_ready(blk, n > 0);
  endtask

  task automatic do_read(input bit rnd, input logic blk, input logic [7:0] addr,
                         input int n, input string rq);
    bit ack;
    logic [7:0] got;
    m_start;
    if (rnd) begin
      m_wbyte(ctrl(blk, 1'b0), ack);
      m_wbyte(addr, ack);
      chk(ack, "R9 addr before restart", ack, 1);
      mptr = {blk, addr};
      m_start;
    end
    m_wbyte(ctrl(blk, 1'b1), ack);
    chk(ack, "R9 read ctrl ack", ack, 1);
    mptr[8] = blk;
    for (int k = 0; k < n; k++) begin
      m_rbyte(k < n - 1, got);
      chk(got === model[mptr], rq, got, model[mptr]);
      mptr = {mptr[8], 8'(mptr[7:0] + 1)};
    end
    chk(!sda_pull, "R7 release after nack", sda_pull, 0);
    m_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    void'($urandom(32'd1234));
    for (int i = 0; i < 512; i++) model[i] = 8'h00;
    mptr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R10 reset state
    chk(!sda_pull, "R10 pull after reset", sda_pull, 0);
    do_read(1'b0, 1'b0, 8'h00, 2, "R10 reset contents");

    // R2 wrong device code and wrong straps
    m_start; m_wbyte(8'b1011_1000, ack); m_stop;
    chk(!ack, "R2 bad code nack", ack, 0);
    m_start; m_wbyte({4'b1010, ~STRAP, 2'b00}, ack); m_stop;
    chk(!ack, "R2 bad strap nack", ack, 0);

    // R1 START inside a byte restarts reception
    m_start; m_bits(8'b1010_0000, 4); m_start;
    m_wbyte(ctrl(1'b0, 1'b0), ack); m_stop;
    chk(ack, "R1 restart mid byte", ack, 1);

    // R4 R5 single byte
    wbuf[0] = 8'hA5;
    do_write(1'b0, 8'h10, 1);
    do_read(1'b1, 1'b0, 8'h10, 1, "R4 byte readback");

    // R5 overlong page rolls over
    for (int k = 0; k < 10; k++) wbuf[k] = 8'(8'h30 + k);
    do_write(1'b1, 8'h3D, 10);
    do_read(1'b1, 1'b1, 8'h38, 8, "R5 page rollover");

    // R8 block wrap in both blocks
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; do_write(1'b0, 8'hFE, 2);
    wbuf[0] = 8'h33; do_write(1'b0, 8'h00, 1);
    do_read(1'b1, 1'b0, 8'hFE, 4, "R8 wrap block0");
    wbuf[0] = 8'h44; wbuf[1] = 8'h55; do_write(1'b1, 8'hFE, 2);
    wbuf[0] = 8'h66; do_write(1'b1, 8'h00, 1);
    do_read(1'b1, 1'b1, 8'hFF, 2, "R8 wrap block1");

    // R9 current address continues after a read
    do_read(1'b0, 1'b1, 8'h00, 2, "R9 current read");

    // random page writes with random and current reads
    for (int it = 0; it < 10; it++) begin
      logic blk;
      logic [7:0] addr;
      int n;
      blk  = 1'($urandom % 2);
      addr = 8'($urandom % 256);
      n    = 1 + int'($urandom % 10);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      do_write(blk, addr, n);
      do_read(1'b1, blk, addr, n, "R7 random seq read");
      do_read(1'b0, blk, 8'h00, 1, "R9 random current read");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule